// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block performs a protected switch from the running task to another task in hardware. It keeps a small table of task descriptors and a memory of task records, one record per task. A request names a switch source and a target task, and carries the current privilege level and the privilege of the requester. The sequencer first checks the target. If the target is acceptable, it writes the live register image into the outgoing task's record, commits the switch, updates the busy and nesting state, and then streams the incoming task's record out as the new register image.

Faults found before the commit point leave every descriptor, every record and the current-task register exactly as they were. A debug trap set in the incoming record is reported only after the switch has completed.

Before any switch, the descriptor table and the record memory are loaded through a simple word port. That port also reads both stores back. Writes on this port take effect only while the sequencer is idle.

Top module: `task_switch_seq`

## Requirements
- R1: After reset the block is idle, `done` and `fault` are low, `cur_task` is 0 and `task_switched` is 0.
- R2: Source codes are CALL=0, JMP=1, IRET=2, INT=3, EXC=4. For CALL and JMP, fault code 1 is raised when `sw_cpl` or `sw_rpl` is numerically greater than the target's DPL (descriptor bits 21:20). INT, EXC and IRET skip this check. The privilege check has priority over the checks in R3 and R4.
- R3: A descriptor is 23 bits: present at bit 22, DPL at 21:20, type at 19:16 and limit at 15:0. Fault code 2 is raised when the target is not present, when its limit is below 0x67, or when its type is not 4'b1001 (available) or 4'b1011 (busy).
- R4: Fault code 3 is raised when the target is busy (type bit 1, which is descriptor bit 17) for CALL, JMP, INT or EXC, or when it is available for IRET.
- R5: A fault before the commit point changes no descriptor, no record word, `cur_task` or `task_switched`.
- R6: The 16-word live image is written to the outgoing record at words 1..16. The image holds general registers 0-7, selectors 8-13, flags 14 and instruction pointer 15. On IRET, bit 14 (the nesting flag) of the saved flags word is cleared.
- R7: The outgoing task's busy bit is cleared on JMP and IRET, and stays set on CALL, INT and EXC.
- R8: The incoming task's busy bit becomes set. For CALL, INT and EXC the outgoing task index is written into word 0 of the incoming record, and bit 14 is set in the loaded flags. For JMP and IRET the stored flags are loaded unchanged. `ctx_out` presents record words 1..16.
- R9: An IRET takes its target from the low index bits of word 0 of the current record, and ignores `sw_tgt`.
- R10: When bit 0 of word 17 of the incoming record is set, the switch completes (`cur_task` is updated and the busy bits are updated), and fault code 4 is reported instead of `done`.
- R11: Source codes 5 to 7 raise fault code 5 and change nothing.
- R12: `done` and `fault` are each one-cycle pulses and are never high together. `fault_code` is 0 alongside `done`. `task_switched` is set by every committed switch.
- R13: A request raised while a switch is in progress is ignored, and produces no further completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_req | input | 1 | Switch request, sampled while idle |
| sw_src | input | 3 | Switch source code |
| sw_tgt | input | 3 | Target task index (not used for IRET) |
| sw_cpl | input | 2 | Current privilege level |
| sw_rpl | input | 2 | Requester privilege level |
| ctx_in | input | 512 | Live register image, word i at bits 32i+31:32i |
| ctx_out | output | 512 | Register image loaded for the incoming task |
| done | output | 1 | Successful switch pulse |
| fault | output | 1 | Fault pulse |
| fault_code | output | 3 | Fault cause, valid with `fault` |
| cur_task | output | 3 | Index of the running task |
| task_switched | output | 1 | Sticky flag set by every committed switch |
| desc_we | input | 1 | Descriptor write strobe (idle only) |
| desc_idx | input | 3 | Descriptor index for write and read |
| desc_wdata | input | 23 | Descriptor write data |
| desc_rdata | output | 23 | Descriptor read data |
| rec_we | input | 1 | Record write strobe (idle only) |
| rec_addr | input | 8 | Record address: task index in bits 7:5, word in bits 4:0 |
| rec_wdata | input | 32 | Record write data |
| rec_rdata | output | 32 | Record read data |

## Verification
The bench uses the default parameters: eight tasks, 32-bit words, eight general registers and six selectors. With these values each source reaches a distinct descriptor, the table holds one descriptor for each failing check, and a 16-cycle save and load window remains for injecting a second request mid-switch. The bench chains the switches so that a CALL-built back link is later followed by an IRET. A second IRET then finds its target already released, which exercises the busy-state fault on the return path.

// File: rtl/task_switch_seq.sv
module task_switch_seq #(
  parameter int NUM_TASKS = 8,
  parameter int DW        = 32,
  parameter int GPRS      = 8,
  parameter int SEGS      = 6,
  parameter int NT_BIT    = 14,
  localparam int IDXW  = $clog2(NUM_TASKS),
  localparam int CTXN  = GPRS + SEGS + 2,
  localparam int RECAW = $clog2(CTXN + 2),
  localparam int DESCW = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_req,
  input  logic [2:0]           sw_src,
  input  logic [IDXW-1:0]      sw_tgt,
  input  logic [1:0]           sw_cpl,
  input  logic [1:0]           sw_rpl,
  input  logic [CTXN*DW-1:0]   ctx_in,
  output logic [CTXN*DW-1:0]   ctx_out,
  output logic                 done,
  output logic                 fault,
  output logic [2:0]           fault_code,
  output logic [IDXW-1:0]      cur_task,
  output logic                 task_switched,
  input  logic                 desc_we,
  input  logic [IDXW-1:0]      desc_idx,
  input  logic [DESCW-1:0]     desc_wdata,
  output logic [DESCW-1:0]     desc_rdata,
  input  logic                 rec_we,
  input  logic [IDXW+RECAW-1:0] rec_addr,
  input  logic [DW-1:0]        rec_wdata,
  output logic [DW-1:0]        rec_rdata
);
  localparam int CW    = $clog2(CTXN);
  localparam int FLG   = GPRS + SEGS;
  localparam int TRAPW = CTXN + 1;
  localparam int BUSY  = 17;
  localparam logic [2:0] SRC_CALL = 3'd0, SRC_JMP = 3'd1, SRC_IRET = 3'd2,
                         SRC_INT = 3'd3, SRC_EXC = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_SAVE, S_COMMIT, S_LOAD} st_t;
  st_t st;

  logic [DW-1:0]    rec_mem  [NUM_TASKS << RECAW];
  logic [DESCW-1:0] desc_mem [NUM_TASKS];
  logic [DW-1:0]    ctx_q    [CTXN];

  logic [2:0]      src_q, fcode_q;
  logic [1:0]      cpl_q, rpl_q;
  logic [IDXW-1:0] tgt_q, cur_q;
  logic [CW-1:0]   cnt;
  logic [DESCW-1:0] tdesc;
  logic [2:0]      chk_code;
  logic [DW-1:0]   save_word, load_word;
  logic [RECAW-1:0] wofs;

  wire is_nest  = (src_q == SRC_CALL) || (src_q == SRC_INT) || (src_q == SRC_EXC);
  wire drop_old = (src_q == SRC_JMP) || (src_q == SRC_IRET);
  wire last     = (cnt == CW'(CTXN - 1));

  assign tdesc      = desc_mem[tgt_q];
  assign wofs       = RECAW'(cnt) + RECAW'(1);
  assign desc_rdata = desc_mem[desc_idx];
  assign rec_rdata  = rec_mem[rec_addr];
  assign cur_task   = cur_q;
  assign fault_code = fcode_q;

  always_comb begin
    if (src_q > SRC_EXC)
      chk_code = 3'd5;
    else if ((src_q == SRC_CALL || src_q == SRC_JMP) &&
             (cpl_q > tdesc[21:20] || rpl_q > tdesc[21:20]))
      chk_code = 3'd1;
    else if (!tdesc[22] || tdesc[15:0] < 16'h0067 ||
             (tdesc[19:16] & 4'b1101) != 4'b1001)
      chk_code = 3'd2;
    else if ((src_q == SRC_IRET) != tdesc[BUSY])
      chk_code = 3'd3;
    else
      chk_code = 3'd0;
  end

  always_comb begin
    save_word = ctx_in[int'(cnt)*DW +: DW];
    if (src_q == SRC_IRET && cnt == CW'(FLG)) save_word[NT_BIT] = 1'b0;
    load_word = rec_mem[{tgt_q, wofs}];
    if (is_nest && cnt == CW'(FLG)) load_word[NT_BIT] = 1'b1;
  end

  for (genvar g = 0; g < CTXN; g++) begin : g_out
    assign ctx_out[g*DW +: DW] = ctx_q[g];
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && rec_we)  rec_mem[rec_addr]  <= rec_wdata;
    if (st == S_IDLE && desc_we) desc_mem[desc_idx] <= desc_wdata;
    if (st == S_SAVE) rec_mem[{cur_q, wofs}] <= save_word;
    if (st == S_COMMIT) begin
      if (is_nest)  rec_mem[{tgt_q, RECAW'(0)}] <= DW'(cur_q);
      if (drop_old) desc_mem[cur_q][BUSY] <= 1'b0;
      desc_mem[tgt_q][BUSY] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src_q <= '0; cpl_q <= '0; rpl_q <= '0; tgt_q <= '0; cur_q <= '0;
      cnt <= '0; fcode_q <= '0;
      done <= 1'b0; fault <= 1'b0; task_switched <= 1'b0;
      for (int i = 0; i < CTXN; i++) ctx_q[i] <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (sw_req) begin
          src_q <= sw_src;
          cpl_q <= sw_cpl;
          rpl_q <= sw_rpl;
          tgt_q <= (sw_src == SRC_IRET) ? rec_mem[{cur_q, RECAW'(0)}][IDXW-1:0] : sw_tgt;
          st    <= S_CHECK;
        end
        S_CHECK: begin
          cnt <= '0;
          if (chk_code != 3'd0) begin
            fault   <= 1'b1;
            fcode_q <= chk_code;
            st      <= S_IDLE;
          end else begin
            st <= S_SAVE;
          end
        end
        S_SAVE: begin
          cnt <= cnt + CW'(1);
          if (last) begin
            cnt <= '0;
            st  <= S_COMMIT;
          end
        end
        S_COMMIT: begin
          cur_q         <= tgt_q;
          task_switched <= 1'b1;
          st            <= S_LOAD;
        end
        S_LOAD: begin
          ctx_q[cnt] <= load_word;
          cnt <= cnt + CW'(1);
          if (last) begin
            cnt <= '0;
            st  <= S_IDLE;
            if (rec_mem[{tgt_q, RECAW'(TRAPW)}][0]) begin
              fault   <= 1'b1;
              fcode_q <= 3'd4;
            end else begin
              done    <= 1'b1;
              fcode_q <= 3'd0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault)); // R12
  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R12
  AST_DONE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault_code == 3'd0)); // R12
  AST_DONE_SETS_TS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> task_switched); // R12
  AST_PRECOMMIT_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_code != 3'd4) |-> $stable(cur_q)); // R5
  AST_NEW_TASK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || (fault && fault_code == 3'd4)) |-> desc_mem[cur_q][BUSY]); // R8
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SAVE && sw_req) |=> $stable(tgt_q)); // R13
endmodule

// File: tb/task_switch_seq_tb.sv
`timescale 1ns/1ps
module task_switch_seq_tb;
  localparam int NT = 8, DW = 32, CTXN = 16, IW = 3, RAW = 5;

  logic clk = 0, rst_n = 0;
  logic sw_req = 0;
  logic [2:0] sw_src = 0;
  logic [IW-1:0] sw_tgt = 0;
  logic [1:0] sw_cpl = 0, sw_rpl = 0;
  logic [CTXN*DW-1:0] ctx_in, ctx_out;
  logic done, fault, task_switched;
  logic [2:0] fault_code;
  logic [IW-1:0] cur_task;
  logic desc_we = 0, rec_we = 0;
  logic [IW-1:0] desc_idx = 0;
  logic [22:0] desc_wdata = 0, desc_rdata;
  logic [IW+RAW-1:0] rec_addr = 0;
  logic [DW-1:0] rec_wdata = 0, rec_rdata;

  task_switch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_src(sw_src), .sw_tgt(sw_tgt),
    .sw_cpl(sw_cpl), .sw_rpl(sw_rpl), .ctx_in(ctx_in), .ctx_out(ctx_out),
    .done(done), .fault(fault), .fault_code(fault_code), .cur_task(cur_task),
    .task_switched(task_switched), .desc_we(desc_we), .desc_idx(desc_idx),
    .desc_wdata(desc_wdata), .desc_rdata(desc_rdata), .rec_we(rec_we),
    .rec_addr(rec_addr), .rec_wdata(rec_wdata), .rec_rdata(rec_rdata));

  always #2 clk = ~clk;

  typedef struct packed { logic ok; logic [2:0] code; logic [IW-1:0] task_idx; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  for (genvar i = 0; i < CTXN; i++) begin : g_ctx
    assign ctx_in[i*DW +: DW] = (i == 14) ? 32'hC000_400E : (32'hC000_0000 | i);
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (done || fault)) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R13 unexpected completion actual %b%b expected none", done, fault);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " completion"}, {28'd0, done, fault_code}, {28'd0, e.ok, e.ok ? 3'd0 : e.code});
        chk({t, " cur_task"}, 32'(cur_task), 32'(e.task_idx));
        chk("R12 exclusive", 32'(done && fault), 32'd0);
      end
    end
  end

  function automatic logic [22:0] mk(input logic p, input logic [1:0] dpl,
                                     input logic [3:0] ty, input logic [15:0] lim);
    return {p, dpl, ty, lim};
  endfunction

  task automatic wr_desc(input int i, input logic [22:0] v);
    @(negedge clk); desc_idx = IW'(i); desc_wdata = v; desc_we = 1;
    @(negedge clk); desc_we = 0;
  endtask

  task automatic wr_rec(input int t, input int w, input logic [31:0] v);
    @(negedge clk); rec_addr = {IW'(t), RAW'(w)}; rec_wdata = v; rec_we = 1;
    @(negedge clk); rec_we = 0;
  endtask

  task automatic rd_rec(input int t, input int w, output logic [31:0] v);
    rec_addr = {IW'(t), RAW'(w)}; #1 v = rec_rdata;
  endtask

  task automatic rd_busy(input int i, output logic b);
    desc_idx = IW'(i); #1 b = desc_rdata[17];
  endtask

  task automatic issue(input logic [2:0] src, input int tgt, input logic [1:0] cpl,
                       input logic [1:0] rpl, input logic ok, input logic [2:0] code,
                       input int tsk, input string tag);
    exp_q.push_back({ok, code, IW'(tsk)});
    tag_q.push_back(tag);
    @(negedge clk);
    sw_src = src; sw_tgt = IW'(tgt); sw_cpl = cpl; sw_rpl = rpl; sw_req = 1;
    @(negedge clk); sw_req = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] ow(input int i);
    return ctx_out[i*DW +: DW];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic b;
    repeat (3) @(negedge clk);
    chk("R1 done", 32'(done), 0);
    chk("R1 fault", 32'(fault), 0);
    chk("R1 cur_task", 32'(cur_task), 0);
    chk("R1 task_switched", 32'(task_switched), 0);
    rst_n = 1;

    wr_desc(0, mk(1, 3, 4'b1011, 16'h67));
    wr_desc(1, mk(1, 3, 4'b1001, 16'h67));
    wr_desc(2, mk(1, 0, 4'b1001, 16'h67));
    wr_desc(3, mk(0, 3, 4'b1001, 16'h67));
    wr_desc(4, mk(1, 3, 4'b1001, 16'h66));
    wr_desc(5, mk(1, 3, 4'b1001, 16'h67));
    wr_desc(6, mk(1, 3, 4'b1001, 16'h80));
    wr_desc(7, mk(1, 3, 4'b0001, 16'h67));
    for (int t = 0; t < NT; t++) begin
      wr_rec(t, 0, (t == 0) ? 32'd1 : (t == 6) ? 32'd7 : 32'd0);
      for (int w = 1; w <= CTXN; w++) wr_rec(t, w, (32'(t) << 16) | 32'(w - 1));
      wr_rec(t, 17, (t == 5) ? 32'd1 : 32'd0);
    end

    issue(3'd0, 2, 2'd3, 2'd3, 0, 3'd1, 0, "R2 call cpl>dpl");
    issue(3'd1, 2, 2'd0, 2'd3, 0, 3'd1, 0, "R2 jmp rpl>dpl");
    issue(3'd0, 3, 2'd0, 2'd0, 0, 3'd2, 0, "R3 not present");
    issue(3'd1, 4, 2'd0, 2'd0, 0, 3'd2, 0, "R3 short limit");
    issue(3'd0, 7, 2'd0, 2'd0, 0, 3'd2, 0, "R3 bad type");
    issue(3'd0, 0, 2'd0, 2'd0, 0, 3'd3, 0, "R4 target busy");
    chk("R5 task_switched", 32'(task_switched), 0);
    rd_rec(0, 1, v);  chk("R5 rec0 word1", v, 32'h0);
    rd_rec(0, 15, v); chk("R5 rec0 flags", v, 32'hE);
    rd_rec(2, 0, v);  chk("R5 rec2 link", v, 32'h0);
    rd_busy(0, b);    chk("R5 desc0 busy", 32'(b), 1);
    rd_busy(2, b);    chk("R5 desc2 busy", 32'(b), 0);

    issue(3'd0, 1, 2'd3, 2'd3, 1, 3'd0, 1, "R8 call");
    for (int i = 0; i < CTXN; i++) begin
      rd_rec(0, i + 1, v);
      chk("R6 saved word", v, (i == 14) ? 32'hC000_400E : (32'hC000_0000 | 32'(i)));
    end
    rd_busy(0, b); chk("R7 call keeps old busy", 32'(b), 1);
    rd_busy(1, b); chk("R8 new busy", 32'(b), 1);
    rd_rec(1, 0, v); chk("R8 back link", v, 32'd0);
    chk("R8 loaded flags nest", ow(14), 32'h0001_400E);
    chk("R8 loaded word0", ow(0), 32'h0001_0000);
    chk("R8 loaded ip", ow(15), 32'h0001_000F);
    chk("R12 task_switched", 32'(task_switched), 1);

    issue(3'd2, 5, 2'd3, 2'd3, 1, 3'd0, 0, "R9 iret via link");
    rd_rec(1, 15, v); chk("R6 iret clears nest", v, 32'hC000_000E);
    rd_busy(1, b); chk("R7 iret clears old busy", 32'(b), 0);
    rd_busy(0, b); chk("R8 iret target stays busy", 32'(b), 1);
    chk("R8 iret flags from image", ow(14), 32'hC000_400E);
    chk("R8 iret word0", ow(0), 32'hC000_0000);

    issue(3'd2, 0, 2'd3, 2'd3, 0, 3'd3, 0, "R4 iret target available");

    issue(3'd1, 6, 2'd3, 2'd3, 1, 3'd0, 6, "R7 jmp");
    rd_busy(0, b); chk("R7 jmp clears old busy", 32'(b), 0);
    rd_busy(6, b); chk("R8 jmp sets busy", 32'(b), 1);
    rd_rec(6, 0, v); chk("R8 jmp keeps link", v, 32'd7);
    chk("R8 jmp flags unchanged", ow(14), 32'h0006_000E);

    issue(3'd3, 2, 2'd3, 2'd3, 1, 3'd0, 2, "R2 int skips privilege");
    rd_busy(6, b); chk("R7 int keeps old busy", 32'(b), 1);
    rd_rec(2, 0, v); chk("R8 int link", v, 32'd6);
    chk("R8 int flags nest", ow(14), 32'h0002_400E);

    issue(3'd4, 5, 2'd3, 2'd3, 0, 3'd4, 5, "R10 trap after commit");
    rd_busy(5, b); chk("R10 trapped task busy", 32'(b), 1);
    rd_rec(5, 0, v); chk("R10 link written", v, 32'd2);
    rd_busy(2, b); chk("R7 exc keeps old busy", 32'(b), 1);

    issue(3'd7, 1, 2'd0, 2'd0, 0, 3'd5, 5, "R11 bad source");
    rd_busy(1, b); chk("R11 nothing changed", 32'(b), 0);

    exp_q.push_back({1'b1, 3'd0, IW'(1)});
    tag_q.push_back("R13 jmp with late request");
    @(negedge clk);
    sw_src = 3'd1; sw_tgt = 1; sw_cpl = 3; sw_rpl = 3; sw_req = 1;
    @(negedge clk); sw_req = 0;
    repeat (3) @(negedge clk);
    sw_src = 3'd0; sw_tgt = 3; sw_req = 1;
    @(negedge clk); sw_req = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (60) @(negedge clk);
    chk("R13 cur_task", 32'(cur_task), 1);
    rd_busy(5, b); chk("R13 jmp released old", 32'(b), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule